// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers asynchronous characters from one serial input line. A clock enable `tick` marks each edge of a receive clock that runs at sixteen times the bit rate. Every step of the block happens on a system clock edge where `tick` is high. The line is first cleaned by a transition filter. A filtered falling edge opens a start-bit check. The frame is accepted only if the line does not return high within the start window.

After the start is accepted, a 16-state phase counter sets the point where each bit is sampled. The counter returns to zero on every filtered transition seen once it has passed state four. Because of this, a sender whose bit period is somewhat off still decodes correctly as long as its data has enough edges. The frame format is set by three static inputs: data length from five to eight bits, parity mode, and stop length. Each finished character gives a one-clock strobe together with the byte and two error flags.

Top module: `ovsUartRx`

## Requirements
- R1: `charLen` selects 5, 6, 7 or 8 data bits (codes 0, 1, 2, 3). Data arrives least significant bit first, and the unused upper bits of `dataOut` read as zero.
- R2: `parMode` 2'b01 selects even parity and 2'b10 selects odd parity, with one parity bit after the data. Codes 2'b00 and 2'b11 mean no parity bit. `parErr` is set when the ones in data plus parity do not match the selected mode, and it is always 0 when there is no parity.
- R3: `frameErr` is set when the first stop bit samples as 0.
- R4: `dataValid` is high for exactly one clock per character, on the clock after the tick that samples the first stop bit. `dataOut`, `parErr` and `frameErr` change only together with that strobe.
- R5: A new line level is taken as the filtered level only on the third consecutive tick that sees it. Shorter pulses have no effect.
- R6: After a filtered falling edge, a filtered rising edge within the next eight ticks drops the attempt and returns to idle, and no character is produced. A later frame is received normally.
- R7: After a start is accepted, a filtered transition seen at phase four or later resets the phase counter to zero. Each bit is sampled from the filtered level when the counter steps to eight. Frames with bit periods of 15, 17 and 18 ticks and enough edges decode correctly.
- R8: `stopLen` 2'b00 returns to idle right at the stop sample. 2'b01 (1.5 bits) waits 8 more ticks first, and 2'b10 or 2'b11 (2 bits) waits 16 more ticks. A falling edge filtered during that wait does not start a frame.
- R9: While `rstN` is low, `dataOut` is 0 and `dataValid`, `parErr` and `frameErr` are 0. The filtered line starts at the idle (high) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | x16 receive clock enable, at most one per clock |
| rxIn | input | 1 | Serial line, synchronous to `clk`, idle high |
| charLen | input | 2 | Data length code (5 + code bits) |
| parMode | input | 2 | Parity mode: 01 even, 10 odd, other none |
| stopLen | input | 2 | Stop length: 00 one, 01 one and a half, 1x two |
| dataOut | output | 8 | Last received character, upper bits zero |
| dataValid | output | 1 | One-clock strobe per received character |
| parErr | output | 1 | Parity mismatch of the last character |
| frameErr | output | 1 | First stop bit of the last character was 0 |

## Verification
The assertions assume that `rxIn` is already synchronous to `clk`, that `tick` is a clean enable, and that the three format inputs do not change while a frame is in progress. The bench drives the line and the format inputs only on falling clock edges. It sets a new format only while the line is idle and high. It pulses `tick` on every second clock, so each stop-sample strobe falls on a clock with a tick just before it.

// File: rtl/ovsRxPkg.sv
package ovsRxPkg;
  localparam int DATA_MAX = 8;
  localparam int IDX_W = $clog2(DATA_MAX);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_GUARD
  } rxState_t;

  typedef struct packed {
    logic             clearShift;
    logic             loadBit;
    logic [IDX_W-1:0] bitIdx;
    logic             loadParity;
    logic             finish;
  } rxStrobe_t;
endpackage

// File: rtl/ovsRxDatapath.sv
module ovsRxDatapath
  import ovsRxPkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                rxIn,
  input  logic [1:0]          parMode,
  input  rxStrobe_t           strobe,
  output logic                filtLevel,
  output logic                flipNow,
  output logic [DATA_MAX-1:0] dataOut,
  output logic                dataValid,
  output logic                parErr,
  output logic                frameErr
);
  localparam int CNT_W = $clog2(FILT_LEN);

  logic [CNT_W-1:0]    runCnt;
  logic [DATA_MAX-1:0] shiftReg;
  logic                parBit;
  logic                onesOdd;
  logic                parErrNext;

  // transition filter: new level must persist for FILT_LEN ticks
  assign flipNow = tick && (rxIn != filtLevel) && (runCnt == CNT_W'(FILT_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtLevel <= 1'b1;
      runCnt    <= '0;
    end else if (tick) begin
      if (rxIn == filtLevel) begin
        runCnt <= '0;
      end else if (flipNow) begin
        filtLevel <= rxIn;
        runCnt    <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  always_comb begin
    onesOdd = (^shiftReg) ^ parBit;
    case (parMode)
      2'b01:   parErrNext = onesOdd;
      2'b10:   parErrNext = ~onesOdd;
      default: parErrNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parBit    <= 1'b0;
      dataOut   <= '0;
      dataValid <= 1'b0;
      parErr    <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      if (strobe.clearShift) begin
        shiftReg <= '0;
        parBit   <= 1'b0;
      end
      if (strobe.loadBit)    shiftReg[strobe.bitIdx] <= filtLevel;
      if (strobe.loadParity) parBit <= filtLevel;
      if (strobe.finish) begin
        dataOut   <= shiftReg;
        dataValid <= 1'b1;
        parErr    <= parErrNext;
        frameErr  <= ~filtLevel;
      end
    end
  end
endmodule

// File: rtl/ovsRxControl.sv
module ovsRxControl
  import ovsRxPkg::*;
#(
  parameter int OVS       = 16,
  parameter int START_WIN = 8,
  parameter int CHECK_PH  = 4,
  parameter int SAMPLE_PH = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      flipNow,
  input  logic      filtLevel,
  input  logic [1:0] charLen,
  input  logic [1:0] parMode,
  input  logic [1:0] stopLen,
  output rxStrobe_t strobe
);
  localparam int PH_W = $clog2(OVS);
  localparam int GD_W = PH_W + 1;

  rxState_t         state;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] bitIdx;
  logic [GD_W-1:0]  guardCnt;
  logic             inBits, resync, sampleNow, riseFlip, fallFlip, parOn;
  logic [IDX_W-1:0] lastIdx;
  logic [GD_W-1:0]  guardEnd;

  always_comb begin
    riseFlip  = flipNow && !filtLevel;
    fallFlip  = flipNow && filtLevel;
    inBits    = (state == ST_DATA) || (state == ST_PARITY) || (state == ST_STOP);
    resync    = inBits && flipNow && (phase >= PH_W'(CHECK_PH));
    sampleNow = inBits && tick && !resync && (phase == PH_W'(SAMPLE_PH - 1));
    parOn     = ^parMode;
    lastIdx   = IDX_W'(DATA_MAX - 4) + IDX_W'(charLen);
    guardEnd  = (stopLen == 2'b01) ? GD_W'(OVS / 2 - 1) : GD_W'(OVS - 1);

    strobe.clearShift = (state == ST_START) && tick && !riseFlip &&
                        (phase == PH_W'(START_WIN - 1));
    strobe.loadBit    = sampleNow && (state == ST_DATA);
    strobe.bitIdx     = bitIdx;
    strobe.loadParity = sampleNow && (state == ST_PARITY);
    strobe.finish     = sampleNow && (state == ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitIdx   <= '0;
      guardCnt <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (fallFlip) begin
            state <= ST_START;
            phase <= '0;
          end
        end
        ST_START: begin
          if (riseFlip) begin
            state <= ST_IDLE;
          end else begin
            phase <= phase + 1'b1;
            if (phase == PH_W'(START_WIN - 1)) begin
              state  <= ST_DATA;
              bitIdx <= '0;
            end
          end
        end
        ST_DATA, ST_PARITY, ST_STOP: begin
          if (resync) begin
            phase <= '0;
          end else begin
            phase <= phase + 1'b1;
            if (sampleNow) begin
              case (state)
                ST_DATA: begin
                  bitIdx <= bitIdx + 1'b1;
                  if (bitIdx == lastIdx) state <= parOn ? ST_PARITY : ST_STOP;
                end
                ST_PARITY: state <= ST_STOP;
                default: begin
                  guardCnt <= '0;
                  state    <= (stopLen == 2'b00) ? ST_IDLE : ST_GUARD;
                end
              endcase
            end
          end
        end
        ST_GUARD: begin
          guardCnt <= guardCnt + 1'b1;
          if (guardCnt == guardEnd) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ovsUartRx.sv
module ovsUartRx
  import ovsRxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxIn,
  input  logic [1:0] charLen,
  input  logic [1:0] parMode,
  input  logic [1:0] stopLen,
  output logic [7:0] dataOut,
  output logic       dataValid,
  output logic       parErr,
  output logic       frameErr
);
  rxStrobe_t ctrlStrobe;
  logic      filtLevel;
  logic      flipNow;

  ovsRxControl #(.OVS(16), .START_WIN(8), .CHECK_PH(4), .SAMPLE_PH(8)) ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .flipNow(flipNow), .filtLevel(filtLevel),
    .charLen(charLen), .parMode(parMode), .stopLen(stopLen), .strobe(ctrlStrobe)
  );

  ovsRxDatapath #(.FILT_LEN(3)) dpath (
    .clk(clk), .rstN(rstN), .tick(tick), .rxIn(rxIn), .parMode(parMode),
    .strobe(ctrlStrobe), .filtLevel(filtLevel), .flipNow(flipNow),
    .dataOut(dataOut), .dataValid(dataValid), .parErr(parErr), .frameErr(frameErr)
  );
endmodule

// File: rtl/ovsRxCheck.sv
module ovsRxCheck (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       rxIn,
  input logic [1:0] charLen,
  input logic [1:0] parMode,
  input logic [7:0] dataOut,
  input logic       dataValid,
  input logic       parErr,
  input logic       frameErr,
  input logic       filtLevel
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && charLen == 2'd0) |-> (dataOut[7:5] == 3'b000));

  assert_no_parity_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && (parMode == 2'b00 || parMode == 2'b11)) |-> !parErr);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  assert_pulse_after_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> $past(tick));

  assert_outputs_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> $stable({dataOut, parErr, frameErr}));

  assert_filter_follows_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtLevel) |-> ($past(tick) && $past(rxIn) == filtLevel));
endmodule

bind ovsUartRx ovsRxCheck chk (
  .clk(clk), .rstN(rstN), .tick(tick), .rxIn(rxIn), .charLen(charLen),
  .parMode(parMode), .dataOut(dataOut), .dataValid(dataValid), .parErr(parErr),
  .frameErr(frameErr), .filtLevel(filtLevel)
);

// File: tb/ovsUartRx_test.sv
`timescale 1ns/1ps
module ovsUartRx_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       rxIn = 1'b1;
  logic [1:0] charLen = 2'd3;
  logic [1:0] parMode = 2'b00;
  logic [1:0] stopLen = 2'b00;
  logic [7:0] dataOut;
  logic       dataValid, parErr, frameErr;

  int checks = 0, failures = 0, cyc = 0;
  int nValid = 0, lastByte = 0, lastPe = 0, lastFe = 0;
  bit prevValid = 0, doubleValid = 0, done = 0;

  // behavioural reference model state
  int mLvl = 1, mRun = 0, mSt = 0, mPh = 0, mIdx = 0, mGd = 0, mShift = 0, mParBit = 0;
  int mOut = 0, mValid = 0, mPe = 0, mFe = 0;

  ovsUartRx uut (.clk(clk), .rstN(rstN), .tick(tick), .rxIn(rxIn), .charLen(charLen),
    .parMode(parMode), .stopLen(stopLen), .dataOut(dataOut), .dataValid(dataValid),
    .parErr(parErr), .frameErr(frameErr));

  always #2 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int oldLvl, flip, ones, len, parOn, odd;
    if (!rstN) begin
      mLvl = 1; mRun = 0; mSt = 0; mPh = 0; mIdx = 0; mGd = 0; mShift = 0; mParBit = 0;
      mOut = 0; mValid = 0; mPe = 0; mFe = 0;
    end else begin
      mValid = 0;
      if (tick) begin
        oldLvl = mLvl; flip = 0;
        if (int'(rxIn) != mLvl) begin
          mRun++;
          if (mRun == 3) begin flip = 1; mLvl = int'(rxIn); mRun = 0; end
        end else mRun = 0;
        len = 5 + int'(charLen);
        parOn = (parMode == 2'b01 || parMode == 2'b10);
        odd = (parMode == 2'b10);
        if (mSt == 0) begin
          if (flip && oldLvl == 1) begin mSt = 1; mPh = 0; end
        end else if (mSt == 1) begin
          if (flip && oldLvl == 0) mSt = 0;
          else begin
            mPh++;
            if (mPh == 8) begin mSt = 2; mIdx = 0; mShift = 0; mParBit = 0; end
          end
        end else if (mSt >= 2 && mSt <= 4) begin
          if (flip && mPh >= 4) mPh = 0;
          else begin
            mPh = (mPh + 1) % 16;
            if (mPh == 8) begin
              if (mSt == 2) begin
                mShift = mShift | (oldLvl << mIdx);
                mIdx++;
                if (mIdx == len) mSt = parOn ? 3 : 4;
              end else if (mSt == 3) begin
                mParBit = oldLvl; mSt = 4;
              end else begin
                ones = $countones(mShift) + mParBit;
                mOut = mShift; mValid = 1; mFe = (oldLvl == 0);
                mPe = parOn && ((ones % 2) == (odd ? 0 : 1));
                mGd = 0;
                mSt = (stopLen == 2'b00) ? 0 : 5;
              end
            end
          end
        end else begin
          mGd++;
          if (mGd == ((stopLen == 2'b01) ? 8 : 16)) mSt = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rstN && !done) begin
      chk("R4 model dataValid", dataValid == mValid[0], int'(dataValid), mValid);
      chk("R1 model dataOut", int'(dataOut) == mOut, int'(dataOut), mOut);
      chk("R2 model parErr", parErr == mPe[0], int'(parErr), mPe);
      chk("R3 model frameErr", frameErr == mFe[0], int'(frameErr), mFe);
      if (dataValid) begin
        nValid++; lastByte = int'(dataOut); lastPe = int'(parErr); lastFe = int'(frameErr);
        if (prevValid) doubleValid = 1;
      end
      prevValid = dataValid;
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitTicks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic sendFrame(input int data, input int nb, input int parOn, input int parV,
                           input int stopV, input int bitT, input int stopT, input int idleT);
    rxIn = 1'b0; waitTicks(bitT);
    for (int i = 0; i < nb; i++) begin rxIn = 1'((data >> i) & 1); waitTicks(bitT); end
    if (parOn != 0) begin rxIn = 1'(parV); waitTicks(bitT); end
    rxIn = 1'(stopV); waitTicks(stopT);
    rxIn = 1'b1; waitTicks(idleT);
  endtask

  task automatic expectChar(input string req, input int cnt, input int b, input int pe, input int fe);
    chk({req, " count"}, nValid == cnt, nValid, cnt);
    chk({req, " byte"}, lastByte == b, lastByte, b);
    chk({req, " parErr"}, lastPe == pe, lastPe, pe);
    chk({req, " frameErr"}, lastFe == fe, lastFe, fe);
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9 reset dataOut", dataOut == 8'h00, int'(dataOut), 0);
    chk("R9 reset flags", {dataValid, parErr, frameErr} == 3'b000, int'({dataValid, parErr, frameErr}), 0);
    rstN = 1'b1;
    waitTicks(20);
    chk("R9 idle after reset", nValid == 0, nValid, 0);

    // R1 eight and six bit characters, LSB first
    sendFrame(8'hA5, 8, 0, 0, 1, 16, 16, 30); expectChar("R1 8N1 A5", 1, 8'hA5, 0, 0);
    sendFrame(8'h3C, 8, 0, 0, 1, 16, 16, 30); expectChar("R1 8N1 3C", 2, 8'h3C, 0, 0);
    charLen = 2'd1;
    sendFrame(8'h2A, 6, 0, 0, 1, 16, 16, 30); expectChar("R1 6 bit", 3, 8'h2A, 0, 0);
    charLen = 2'd0;
    sendFrame(8'hFF, 5, 0, 0, 1, 16, 16, 30); expectChar("R1 5 bit upper zero", 4, 8'h1F, 0, 0);

    // R2 parity
    parMode = 2'b01;
    sendFrame(8'h13, 5, 1, 1, 1, 16, 16, 30); expectChar("R2 even good", 5, 8'h13, 0, 0);
    sendFrame(8'h13, 5, 1, 0, 1, 16, 16, 30); expectChar("R2 even bad", 6, 8'h13, 1, 0);
    charLen = 2'd2; parMode = 2'b10;
    sendFrame(8'h55, 7, 1, 1, 1, 16, 16, 30); expectChar("R2 odd good", 7, 8'h55, 0, 0);
    sendFrame(8'h55, 7, 1, 0, 1, 16, 16, 30); expectChar("R2 odd bad", 8, 8'h55, 1, 0);

    // R3 framing error
    charLen = 2'd3; parMode = 2'b00;
    sendFrame(8'h81, 8, 0, 0, 0, 16, 16, 30); expectChar("R3 stop low", 9, 8'h81, 0, 1);
    sendFrame(8'h42, 8, 0, 0, 1, 16, 16, 30); expectChar("R3 clears", 10, 8'h42, 0, 0);

    // R5 short pulses ignored
    rxIn = 1'b0; waitTicks(2); rxIn = 1'b1; waitTicks(40);
    rxIn = 1'b0; waitTicks(1); rxIn = 1'b1; waitTicks(40);
    chk("R5 glitch ignored", nValid == 10, nValid, 10);

    // R6 false start
    rxIn = 1'b0; waitTicks(6); rxIn = 1'b1; waitTicks(40);
    chk("R6 false start dropped", nValid == 10, nValid, 10);
    sendFrame(8'h96, 8, 0, 0, 1, 16, 16, 30); expectChar("R6 next frame", 11, 8'h96, 0, 0);

    // R7 resync on off-rate senders
    sendFrame(8'h55, 8, 0, 0, 1, 17, 17, 30); expectChar("R7 slow 17", 12, 8'h55, 0, 0);
    sendFrame(8'hAA, 8, 0, 0, 1, 15, 15, 30); expectChar("R7 fast 15", 13, 8'hAA, 0, 0);
    sendFrame(8'h55, 8, 0, 0, 1, 18, 18, 30); expectChar("R7 slow 18", 14, 8'h55, 0, 0);

    // R8 stop length guard: second start falls 20 ticks into first stop bit
    stopLen = 2'b00; base = nValid;
    sendFrame(8'hC3, 8, 0, 0, 1, 16, 20, 0); sendFrame(8'h00, 8, 0, 0, 1, 16, 16, 40);
    expectChar("R8 one stop", base + 2, 8'h00, 0, 0);
    stopLen = 2'b01; base = nValid;
    sendFrame(8'hC3, 8, 0, 0, 1, 16, 20, 0); sendFrame(8'h00, 8, 0, 0, 1, 16, 16, 40);
    expectChar("R8 one and half stop", base + 2, 8'h00, 0, 0);
    stopLen = 2'b10; base = nValid;
    sendFrame(8'hC3, 8, 0, 0, 1, 16, 20, 0); sendFrame(8'h00, 8, 0, 0, 1, 16, 16, 40);
    expectChar("R8 two stop masks start", base + 1, 8'hC3, 0, 0);

    chk("R4 strobe one clock wide", doubleValid == 0, int'(doubleValid), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule